// File: doc/BRIEF.md
# DDR Write-Path Command Timing Checker

This block watches a decoded DDR SDRAM command stream together with the write-data pair strobes and keeps, for each of four banks, the timing windows that a write burst leaves behind. When the final data pair of a write burst is registered, the bank that was written gets a write-to-read window and a write-recovery window. If the write asked for auto-precharge, the bank also closes and a row-precharge window starts. An explicit precharge closes a bank and starts the same row-precharge window.

Each command is judged against its bank's windows. Any command that lands inside a window produces a one-cycle violation pulse with a cause code. The windows themselves are reported as per-bank "allowed" levels that a scheduler can use to gate its choices. A READ or PRECHARGE aimed at the bank of a burst that is still receiving data truncates that burst. The checker then reports how many of the burst's data pairs survive, meaning the pairs registered before the truncating command's window. All window lengths are programmable in clock cycles.

Top module: `ddr_wr_timing_chk`

## Requirements
- R1: While reset is held and after it is released, every bank is closed, `rd_ok_o`, `pre_ok_o` and `act_ok_o` are all ones, and `viol_o` and `trunc_o` are low.
- R2: When the final pair of a burst is registered in cycle c (`pair_i` and `last_i` high), the burst's bank refuses READs in cycles c+1 to c+`t_wtr_i`. Such a READ gives cause 01. From cycle c+`t_wtr_i`+1 on, a READ is accepted. `rd_ok_o` is low exactly across that window.
- R3: The same completion refuses PRECHARGE to that bank in cycles c+1 to c+`t_wr_i`, with cause 10. `pre_ok_o` is low across that window.
- R4: A PRECHARGE command (code 4) in cycle c closes its bank. Any command to that bank in cycles c+1 to c+`t_rp_i` gives cause 11, and `act_ok_o` is low across that window.
- R5: A burst whose WRITE carried `auto_pre_i` closes its bank and starts the row-precharge window of R4 in the cycle of its completion. An ACTIVATE (code 1) opens a bank and takes precedence over an auto-precharge that completes in the same cycle on the same bank.
- R6: When a bank is inside the row-precharge window, the cause is 11 even if a write-to-read or write-recovery window is also running.
- R7: Command codes are: 0 no-op, 1 ACTIVATE, 2 READ, 3 WRITE, 4 PRECHARGE. A violation shows as `viol_o` high for exactly one cycle, the cycle after the offending command, with `cause_o` set to 01, 10 or 11. A no-op never produces a violation.
- R8: A READ or PRECHARGE to the bank of an open burst that has not completed, including in the cycle of its final pair, truncates the burst. Truncation loads neither write window nor auto-precharge. In the next cycle `trunc_o` pulses, and `kept_o` gives the number of the burst's pairs registered more than T cycles before the command (T = `t_wtr_i` for READ, `t_wr_i` for PRECHARGE). A pair in the command's own cycle is dropped.
- R9: A WRITE (code 3) while a burst is open completes the old burst, loading its windows and auto-precharge as in R2, R3 and R5, and opens a new burst for the new bank. Pairs count only from the cycle after the WRITE.
- R10: Windows are per bank: commands to other banks are judged only against their own windows. A programmed count of zero opens no window.
- R11: `pair_i` and `last_i` have no effect while no burst is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| t_wtr_i | input | CNT_W | Write-to-read window in cycles |
| t_wr_i | input | CNT_W | Write-recovery window in cycles |
| t_rp_i | input | CNT_W | Row-precharge window in cycles |
| cmd_i | input | 3 | Decoded command code |
| bank_i | input | BANK_W | Bank of the command |
| auto_pre_i | input | 1 | Auto-precharge flag of a WRITE |
| pair_i | input | 1 | A write data pair is registered this cycle |
| last_i | input | 1 | This cycle's pair is the burst's final pair |
| rd_ok_o | output | NB | Per bank: READ allowed |
| pre_ok_o | output | NB | Per bank: PRECHARGE allowed |
| act_ok_o | output | NB | Per bank: any command allowed |
| open_o | output | NB | Per bank: row open |
| viol_o | output | 1 | Violation pulse |
| cause_o | output | 2 | Violation cause |
| trunc_o | output | 1 | Truncation report pulse |
| kept_o | output | PAIR_W | Pairs that survive the truncation |

## Verification
Two functions can fall into the same cycle. One is the completion of a burst by its final pair; the other is a READ or PRECHARGE aimed at that burst's bank. The bench provokes this by driving the last pair and a PRECHARGE together, and it expects a truncation report with that pair dropped and no write-recovery window afterwards. Auto-precharge completion meeting an ACTIVATE on the same bank, and a new WRITE meeting the old burst's end, are driven the same way. A behavioural model with per-bank integer counters and a queue of pair timestamps is compared with every output on every clock.

// File: rtl/ddr_wtc_pkg.sv
package ddr_wtc_pkg;
  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4
  } cmd_e;

  typedef enum logic [1:0] {
    CAUSE_NONE = 2'b00,
    CAUSE_WTR  = 2'b01,
    CAUSE_WR   = 2'b10,
    CAUSE_RP   = 2'b11
  } cause_e;
endpackage

// File: rtl/ddr_wtc_cnt.sv
module ddr_wtc_cnt #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  output logic             busy_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - CNT_W'(1);
  end

  assign busy_o = (cnt_q != '0);

  // R4: a nonzero reload opens a window
  assert_cnt_reload_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && (val_i != '0) |=> busy_o);
  // R2: window closes after its last counted cycle
  assert_cnt_expire_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i && (cnt_q == CNT_W'(1)) |=> !busy_o);
endmodule

// File: rtl/ddr_wtc_bank.sv
module ddr_wtc_bank #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] t_wtr_i,
  input  logic [CNT_W-1:0] t_wr_i,
  input  logic [CNT_W-1:0] t_rp_i,
  input  logic             done_i,
  input  logic             done_ap_i,
  input  logic             pre_i,
  input  logic             act_i,
  output logic             wtr_busy_o,
  output logic             wr_busy_o,
  output logic             rp_busy_o,
  output logic             open_o
);
  logic close_ev;
  logic open_q;

  assign close_ev = pre_i || (done_i && done_ap_i);

  ddr_wtc_cnt #(.CNT_W(CNT_W)) u_wtr (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(done_i), .val_i(t_wtr_i), .busy_o(wtr_busy_o));
  ddr_wtc_cnt #(.CNT_W(CNT_W)) u_wr (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(done_i), .val_i(t_wr_i), .busy_o(wr_busy_o));
  ddr_wtc_cnt #(.CNT_W(CNT_W)) u_rp (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(close_ev), .val_i(t_rp_i), .busy_o(rp_busy_o));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       open_q <= 1'b0;
    else if (act_i)    open_q <= 1'b1;
    else if (close_ev) open_q <= 1'b0;
  end

  assign open_o = open_q;

  assert_pre_close_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_i |=> !open_o);
  assert_ap_close_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i && done_ap_i && !act_i |=> !open_o);
  assert_act_open_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i |=> open_o);
endmodule

// File: rtl/ddr_wtc_burst.sv
module ddr_wtc_burst
  import ddr_wtc_pkg::*;
#(
  parameter int NB     = 4,
  parameter int CNT_W  = 4,
  parameter int PAIR_W = 4,
  localparam int BANK_W = $clog2(NB),
  localparam int HIST   = 1 << CNT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  cmd_e              cmd_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic              auto_pre_i,
  input  logic              pair_i,
  input  logic              last_i,
  input  logic [CNT_W-1:0]  t_wtr_i,
  input  logic [CNT_W-1:0]  t_wr_i,
  output logic              done_o,
  output logic [BANK_W-1:0] done_bank_o,
  output logic              done_ap_o,
  output logic              trunc_o,
  output logic [PAIR_W-1:0] kept_o
);
  logic              act_q, ap_q;
  logic [BANK_W-1:0] bank_q;
  logic [PAIR_W-1:0] pairs_q, dropped;
  logic [HIST-1:0]   hist_q;   // bit k: pair registered k+1 cycles ago
  logic [CNT_W-1:0]  win;
  logic              is_wr, is_rd, is_pre;

  assign is_wr  = (cmd_i == CMD_WR);
  assign is_rd  = (cmd_i == CMD_RD);
  assign is_pre = (cmd_i == CMD_PRE);

  assign trunc_o     = act_q && (is_rd || is_pre) && (bank_i == bank_q);
  assign done_o      = act_q && !trunc_o && ((pair_i && last_i) || is_wr);
  assign done_bank_o = bank_q;
  assign done_ap_o   = ap_q;
  assign win         = is_rd ? t_wtr_i : t_wr_i;

  always_comb begin
    dropped = '0;
    for (int k = 0; k < HIST; k++)
      if ((k < int'(win)) && hist_q[k]) dropped = dropped + PAIR_W'(1);
  end

  assign kept_o = pairs_q - dropped;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q   <= 1'b0;
      ap_q    <= 1'b0;
      bank_q  <= '0;
      pairs_q <= '0;
      hist_q  <= '0;
    end else if (is_wr) begin
      act_q   <= 1'b1;
      ap_q    <= auto_pre_i;
      bank_q  <= bank_i;
      pairs_q <= '0;
      hist_q  <= '0;
    end else begin
      hist_q <= {hist_q[HIST-2:0], act_q && pair_i};
      if (trunc_o || done_o)    act_q   <= 1'b0;
      else if (act_q && pair_i) pairs_q <= pairs_q + PAIR_W'(1);
    end
  end

  assert_kept_range_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trunc_o |-> (dropped <= pairs_q));
  assert_wr_opens_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_wr |=> act_q);
endmodule

// File: rtl/ddr_wr_timing_chk.sv
module ddr_wr_timing_chk
  import ddr_wtc_pkg::*;
#(
  parameter int NB     = 4,
  parameter int CNT_W  = 4,
  parameter int PAIR_W = 4,
  localparam int BANK_W = $clog2(NB)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CNT_W-1:0]  t_wtr_i,
  input  logic [CNT_W-1:0]  t_wr_i,
  input  logic [CNT_W-1:0]  t_rp_i,
  input  logic [2:0]        cmd_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic              auto_pre_i,
  input  logic              pair_i,
  input  logic              last_i,
  output logic [NB-1:0]     rd_ok_o,
  output logic [NB-1:0]     pre_ok_o,
  output logic [NB-1:0]     act_ok_o,
  output logic [NB-1:0]     open_o,
  output logic              viol_o,
  output logic [1:0]        cause_o,
  output logic              trunc_o,
  output logic [PAIR_W-1:0] kept_o
);
  cmd_e              cmd;
  logic              done, done_ap, trunc;
  logic [BANK_W-1:0] done_bank;
  logic [PAIR_W-1:0] kept;
  logic [NB-1:0]     wtr_busy, wr_busy, rp_busy;
  cause_e            cause_d, cause_q;
  logic              trunc_q;
  logic [PAIR_W-1:0] kept_q;

  assign cmd = cmd_e'(cmd_i);

  ddr_wtc_burst #(.NB(NB), .CNT_W(CNT_W), .PAIR_W(PAIR_W)) u_burst (
    .clk_i(clk_i), .rst_ni(rst_ni), .cmd_i(cmd), .bank_i(bank_i),
    .auto_pre_i(auto_pre_i), .pair_i(pair_i), .last_i(last_i),
    .t_wtr_i(t_wtr_i), .t_wr_i(t_wr_i),
    .done_o(done), .done_bank_o(done_bank), .done_ap_o(done_ap),
    .trunc_o(trunc), .kept_o(kept));

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic sel;
    assign sel = (bank_i == BANK_W'(b));
    ddr_wtc_bank #(.CNT_W(CNT_W)) u_bank (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .t_wtr_i(t_wtr_i), .t_wr_i(t_wr_i), .t_rp_i(t_rp_i),
      .done_i(done && (done_bank == BANK_W'(b))),
      .done_ap_i(done_ap),
      .pre_i(sel && (cmd == CMD_PRE)),
      .act_i(sel && (cmd == CMD_ACT)),
      .wtr_busy_o(wtr_busy[b]), .wr_busy_o(wr_busy[b]),
      .rp_busy_o(rp_busy[b]), .open_o(open_o[b]));
    assign rd_ok_o[b]  = !rp_busy[b] && !wtr_busy[b];
    assign pre_ok_o[b] = !rp_busy[b] && !wr_busy[b];
    assign act_ok_o[b] = !rp_busy[b];
  end

  // tRP dominates the write windows
  always_comb begin
    cause_d = CAUSE_NONE;
    if (cmd != CMD_NOP) begin
      if (rp_busy[bank_i])                         cause_d = CAUSE_RP;
      else if ((cmd == CMD_RD)  && wtr_busy[bank_i]) cause_d = CAUSE_WTR;
      else if ((cmd == CMD_PRE) && wr_busy[bank_i])  cause_d = CAUSE_WR;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cause_q <= CAUSE_NONE;
      trunc_q <= 1'b0;
      kept_q  <= '0;
    end else begin
      cause_q <= cause_d;
      trunc_q <= trunc;
      kept_q  <= trunc ? kept : '0;
    end
  end

  assign viol_o  = (cause_q != CAUSE_NONE);
  assign cause_o = cause_q;
  assign trunc_o = trunc_q;
  assign kept_o  = kept_q;

  assert_nop_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == 3'd0) |=> !viol_o);
  assert_rp_priority_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i != 3'd0) && rp_busy[bank_i] |=> (cause_o == 2'b11));
  assert_viol_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_o && (cmd_i == 3'd0) |=> !viol_o);
endmodule

// File: tb/ddr_wr_timing_chk_bench.sv
`timescale 1ns/1ps
module ddr_wr_timing_chk_bench;
  localparam int NB = 4;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] t_wtr, t_wr, t_rp;
  logic [2:0] cmd;
  logic [1:0] bank;
  logic       ap, pair, last;
  logic [3:0] rd_ok, pre_ok, act_ok, open_v;
  logic       viol, trunc;
  logic [1:0] cause;
  logic [3:0] kept;

  always #2.5 clk = ~clk;

  ddr_wr_timing_chk u_ddr_wr_timing_chk (
    .clk_i(clk), .rst_ni(rst_ni), .t_wtr_i(t_wtr), .t_wr_i(t_wr), .t_rp_i(t_rp),
    .cmd_i(cmd), .bank_i(bank), .auto_pre_i(ap), .pair_i(pair), .last_i(last),
    .rd_ok_o(rd_ok), .pre_ok_o(pre_ok), .act_ok_o(act_ok), .open_o(open_v),
    .viol_o(viol), .cause_o(cause), .trunc_o(trunc), .kept_o(kept));

  int n_run = 0, n_fail = 0;
  bit fin = 0;
  string req = "R1";

  // reference model
  int m_wtr[NB], m_wr[NB], m_rp[NB];
  bit m_open[NB];
  bit b_act, b_ap;
  int b_bank;
  int ptimes[$];
  int cyc = 0;
  int e_cause, e_kept;
  bit e_tr;

  task automatic chk(bit ok, string what, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic compare();
    logic [3:0] erd, epre, eact, eop;
    for (int k = 0; k < NB; k++) begin
      erd[k]  = (m_rp[k] == 0) && (m_wtr[k] == 0);
      epre[k] = (m_rp[k] == 0) && (m_wr[k] == 0);
      eact[k] = (m_rp[k] == 0);
      eop[k]  = m_open[k];
    end
    chk(viol == (e_cause != 0), "viol", int'(viol), int'(e_cause != 0));
    chk(int'(cause) == e_cause, "cause", int'(cause), e_cause);
    chk(trunc == e_tr, "trunc", int'(trunc), int'(e_tr));
    if (e_tr) chk(int'(kept) == e_kept, "kept", int'(kept), e_kept);
    chk(rd_ok == erd, "rd_ok", int'(rd_ok), int'(erd));
    chk(pre_ok == epre, "pre_ok", int'(pre_ok), int'(epre));
    chk(act_ok == eact, "act_ok", int'(act_ok), int'(eact));
    chk(open_v == eop, "open", int'(open_v), int'(eop));
  endtask

  // codes: 0 nop, 1 act, 2 rd, 3 wr, 4 pre
  task automatic step(int c, int b, int a = 0, int p = 0, int l = 0);
    bit done;
    int tw;
    cmd = 3'(c); bank = 2'(b); ap = a[0]; pair = p[0]; last = l[0];
    e_cause = 0; e_kept = 0;
    if (c != 0) begin
      if (m_rp[b] > 0)                 e_cause = 3;
      else if (c == 2 && m_wtr[b] > 0) e_cause = 1;
      else if (c == 4 && m_wr[b] > 0)  e_cause = 2;
    end
    e_tr = b_act && (c == 2 || c == 4) && (b == b_bank);
    if (e_tr) begin
      tw = (c == 2) ? int'(t_wtr) : int'(t_wr);
      foreach (ptimes[i]) if (ptimes[i] < cyc - tw) e_kept++;
    end
    done = b_act && !e_tr && ((p != 0 && l != 0) || c == 3);
    @(posedge clk);
    for (int k = 0; k < NB; k++) begin
      if (m_wtr[k] > 0) m_wtr[k]--;
      if (m_wr[k] > 0)  m_wr[k]--;
      if (m_rp[k] > 0)  m_rp[k]--;
    end
    if (done) begin
      m_wtr[b_bank] = int'(t_wtr);
      m_wr[b_bank]  = int'(t_wr);
      if (b_ap) begin m_rp[b_bank] = int'(t_rp); m_open[b_bank] = 0; end
    end
    if (c == 4) begin m_rp[b] = int'(t_rp); m_open[b] = 0; end
    if (c == 1) m_open[b] = 1;
    if (c == 3) begin b_act = 1; b_bank = b; b_ap = a[0]; ptimes.delete(); end
    else if (e_tr || done) b_act = 0;
    else if (b_act && p != 0) ptimes.push_back(cyc);
    cyc++;
    @(negedge clk);
    compare();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!fin) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    t_wtr = 4'd2; t_wr = 4'd3; t_rp = 4'd2;
    cmd = 3'd0; bank = 2'd0; ap = 0; pair = 0; last = 0;
    for (int k = 0; k < NB; k++) begin m_wtr[k] = 0; m_wr[k] = 0; m_rp[k] = 0; m_open[k] = 0; end
    b_act = 0; b_ap = 0; b_bank = 0;
    e_cause = 0; e_tr = 0; e_kept = 0;
    repeat (3) @(negedge clk);
    req = "R1";
    compare();
    rst_ni = 1'b1;
    step(0, 0);

    req = "R2";  // READs after completion on bank 0
    step(1, 0); step(3, 0); step(0, 0, 0, 1); step(0, 0, 0, 1, 1);
    step(2, 0); step(2, 0); step(2, 0); step(2, 0);

    req = "R3";  // PRECHARGE during tWR, then tRP takes over
    step(1, 1); step(3, 1); step(0, 0, 0, 1, 1);
    step(4, 1); step(0, 0);
    req = "R6";
    step(2, 1); step(4, 1); idle(4);

    req = "R4";
    step(1, 2); step(4, 2); step(1, 2); step(3, 2); step(1, 2); step(1, 2); idle(3);

    req = "R5";  // auto-precharge closes bank 3
    step(1, 3); step(3, 3, 1); step(0, 0, 0, 1); step(0, 0, 0, 1, 1);
    step(1, 3); step(1, 3); step(1, 3); idle(3);
    step(3, 3, 1); step(0, 0, 0, 1); step(1, 3, 0, 1, 1); idle(4);

    req = "R8";  // READ truncation, long burst
    step(1, 0); step(3, 0);
    for (int i = 0; i < 5; i++) step(0, 0, 0, 1);
    step(2, 0); idle(3);
    // PRECHARGE in the same cycle as the final pair
    t_wr = 4'd1;
    step(1, 1); step(3, 1); step(0, 0, 0, 1); step(0, 0, 0, 1); step(0, 0); step(0, 0, 0, 1);
    step(4, 1, 0, 1, 1); idle(4);
    t_wr = 4'd3;

    req = "R9";  // back-to-back WRITE closes old burst
    step(1, 2); step(3, 2); step(0, 0, 0, 1); step(3, 3, 0, 1); step(2, 2);
    step(0, 0, 0, 1); step(2, 3); step(0, 0, 0, 1, 1); step(2, 3); idle(4);

    req = "R10";  // other banks unaffected, zero counts
    step(1, 0); step(3, 0); step(0, 0, 0, 1, 1);
    step(2, 1); step(4, 2); step(2, 0); idle(4);
    t_wtr = 4'd0; t_wr = 4'd0;
    step(3, 0); step(0, 0, 0, 1, 1); step(2, 0); step(4, 0); idle(3);
    t_wtr = 4'd2; t_wr = 4'd3;

    req = "R11";  // strobes with no burst open
    step(0, 0, 0, 1, 1); step(0, 0, 0, 1, 1); step(2, 1); step(2, 3); idle(3);

    req = "R7";
    step(1, 1); step(3, 1); step(0, 0, 0, 1, 1); step(2, 1); step(0, 0); idle(4);

    fin = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule